// File: doc/BRIEF.md
# Bitmap Sparse Index Decoder

This block turns a 16-bit occupancy bitmap into a stream of addresses for a zero-skipping multiply-accumulate datapath. Each set bit marks a nonzero activation. After a load, the block walks the set bits from the lowest position upward and emits one address pair per clock. The pair holds a 4-bit dense position, which addresses the weight store, and a 10-bit compacted counter, which addresses the activation store where only the nonzero values sit back to back.

The counter starts from an absolute offset given with each load instead of from zero. Successive bitmap words can therefore walk consecutive slices of one packed activation store. Internally, a population count of the incoming bitmap sets the number of emissions. The lowest set bit of the held bitmap is isolated each cycle and then cleared, so there is no scan. A completion flag rises once every set bit has been emitted and holds until the next accepted load.

Top module: `sparse_idx_decoder`

## Requirements
- R1: While reset is low and in the first cycle after reset, `valid_o` and `done_o` are 0 and `pos_o` and `fetch_o` are 0.
- R2: A load (`load_i` high at a clock edge) is accepted when the block is idle or done. After that edge, `fetch_o` equals the `base_i` value sampled with the load.
- R3: For a bitmap with n set bits (n > 0), `valid_o` is high for exactly n consecutive cycles starting the cycle after the load. `pos_o` shows the set-bit positions in strictly ascending order, one per cycle, and each shown position is a set bit of the loaded bitmap.
- R4: During the k-th emission (k counted from 0), `fetch_o` equals the load offset plus k, modulo 1024.
- R5: An all-zero bitmap makes `done_o` rise the cycle after the load with no `valid_o` pulse.
- R6: `done_o` rises the cycle after the last emission and stays high until the next accepted load. While done, `fetch_o` holds the offset plus the number of set bits, modulo 1024. `done_o` and `valid_o` are never high together.
- R7: `load_i` asserted while emissions are in progress is ignored, and the ongoing sequence of positions and counter values continues unchanged.
- R8: `pos_o` is 0 whenever `valid_o` is low.
- R9: Boundary bitmaps behave like any other. A full bitmap emits positions 0 through 15. A lone bit 15 emits position 15. The counter wraps from 1023 to 0 in mid-sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Load request for a new bitmap and offset |
| map_i | input | 16 | Occupancy bitmap, bit i set means element i is nonzero |
| base_i | input | 10 | Absolute start address in the packed activation store |
| valid_o | output | 1 | An address pair is presented this cycle |
| pos_o | output | 4 | Dense position of the current nonzero (weight address) |
| fetch_o | output | 10 | Compacted counter (packed activation address) |
| done_o | output | 1 | All set bits of the loaded bitmap have been emitted |

## Verification
The hardest situation to reach from the ports is a load request that arrives while a walk is still in progress. It has to be ignored without disturbing the position order or the counter. The stimulus holds `load_i` high for several cycles in the middle of a long walk, with a different bitmap and offset on the inputs, and the reference model keeps expecting the original sequence. The counter wrap at 1023 is reached by loading an offset just below the top of the range with a bitmap that has enough set bits to cross it. Back-to-back loads issued in the first done cycle and the all-zero bitmap cover the remaining corners of the state machine.

// File: rtl/sparse_idx_pkg.sv
package sparse_idx_pkg;

    // Phases of the bitmap walk
    typedef enum logic [1:0] {
        WALK_IDLE = 2'd0,
        WALK_EMIT = 2'd1,
        WALK_DONE = 2'd2
    } walk_state_e;

endpackage

// File: rtl/sidx_popcount.sv
// Combinational population count built as a running-sum chain.
module sidx_popcount #(
    parameter int W     = 16,
    localparam int CW   = $clog2(W + 1)
) (
    input  logic [W-1:0]  vec_i,
    output logic [CW-1:0] cnt_o
);

    logic [CW-1:0] partial [W+1];

    assign partial[0] = '0;

    for (genvar g = 0; g < W; g++) begin : g_sum
        assign partial[g+1] = partial[g] + CW'(vec_i[g]);
    end

    assign cnt_o = partial[W];

endmodule

// File: rtl/sidx_lowbit.sv
// Isolates the lowest set bit, encodes its index and produces the
// vector with that bit removed.
module sidx_lowbit #(
    parameter int W    = 16,
    localparam int IW  = $clog2(W)
) (
    input  logic [W-1:0]  vec_i,
    output logic          any_o,
    output logic [IW-1:0] idx_o,
    output logic [W-1:0]  rest_o
);

    logic [W-1:0] onehot;

    // two's complement trick: v & -v keeps only the lowest one
    assign onehot = vec_i & (~vec_i + W'(1));
    assign rest_o = vec_i & (vec_i - W'(1));
    assign any_o  = |vec_i;

    // one-hot to binary: OR of the indices whose bit is set
    always_comb begin
        idx_o = '0;
        for (int i = 0; i < W; i++) begin
            if (onehot[i]) begin
                idx_o = idx_o | IW'(i);
            end
        end
    end

endmodule

// File: rtl/sidx_walker.sv
// Load / emit / done controller holding the bitmap, the remaining
// count and the compacted fetch counter.
module sidx_walker
    import sparse_idx_pkg::*;
#(
    parameter int W       = 16,
    parameter int FW      = 10,
    localparam int CW     = $clog2(W + 1)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          load_i,
    input  logic [W-1:0]  map_i,
    input  logic [FW-1:0] base_i,
    input  logic [CW-1:0] load_cnt_i,
    input  logic [W-1:0]  rest_i,
    output logic [W-1:0]  map_o,
    output logic          emit_o,
    output logic          done_o,
    output logic [FW-1:0] fetch_o
);

    typedef struct packed {
        walk_state_e   st;
        logic [W-1:0]  map;
        logic [CW-1:0] rem;
        logic [FW-1:0] fetch;
    } walk_regs_t;

    walk_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            WALK_IDLE, WALK_DONE: begin
                if (load_i) begin
                    r_d.map   = map_i;
                    r_d.rem   = load_cnt_i;
                    r_d.fetch = base_i;
                    r_d.st    = (load_cnt_i == '0) ? WALK_DONE : WALK_EMIT;
                end
            end
            WALK_EMIT: begin
                r_d.map   = rest_i;
                r_d.rem   = r_q.rem - CW'(1);
                r_d.fetch = r_q.fetch + FW'(1);
                if (r_q.rem == CW'(1)) begin
                    r_d.st = WALK_DONE;
                end
            end
            default: begin
                r_d.st = WALK_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q.st    <= WALK_IDLE;
            r_q.map   <= '0;
            r_q.rem   <= '0;
            r_q.fetch <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign map_o   = r_q.map;
    assign emit_o  = (r_q.st == WALK_EMIT);
    assign done_o  = (r_q.st == WALK_DONE);
    assign fetch_o = r_q.fetch;

endmodule

// File: rtl/sparse_idx_decoder.sv
// Top: bitmap walker producing dense position and compacted counter.
module sparse_idx_decoder #(
    parameter int MAP_W    = 16,
    parameter int FETCH_W  = 10,
    localparam int POS_W   = $clog2(MAP_W),
    localparam int CNT_W   = $clog2(MAP_W + 1)
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               load_i,
    input  logic [MAP_W-1:0]   map_i,
    input  logic [FETCH_W-1:0] base_i,
    output logic               valid_o,
    output logic [POS_W-1:0]   pos_o,
    output logic [FETCH_W-1:0] fetch_o,
    output logic               done_o
);

    logic [CNT_W-1:0] in_cnt;
    logic [MAP_W-1:0] held_map;
    logic [MAP_W-1:0] lb_rest;
    logic [POS_W-1:0] lb_idx;
    logic             lb_any;
    logic             emit;

    sidx_popcount #(.W(MAP_W)) u_pcnt (
        .vec_i (map_i),
        .cnt_o (in_cnt)
    );

    sidx_lowbit #(.W(MAP_W)) u_low (
        .vec_i  (held_map),
        .any_o  (lb_any),
        .idx_o  (lb_idx),
        .rest_o (lb_rest)
    );

    sidx_walker #(.W(MAP_W), .FW(FETCH_W)) u_walk (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .load_i     (load_i),
        .map_i      (map_i),
        .base_i     (base_i),
        .load_cnt_i (in_cnt),
        .rest_i     (lb_rest),
        .map_o      (held_map),
        .emit_o     (emit),
        .done_o     (done_o),
        .fetch_o    (fetch_o)
    );

    assign valid_o = emit;
    assign pos_o   = emit ? lb_idx : '0;

endmodule

// File: rtl/sparse_idx_decoder_chk.sv
module sparse_idx_decoder_chk #(
    parameter int MAP_W    = 16,
    parameter int FETCH_W  = 10,
    localparam int POS_W   = $clog2(MAP_W)
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               load_i,
    input  logic [MAP_W-1:0]   map_i,
    input  logic [FETCH_W-1:0] base_i,
    input  logic               valid_i,
    input  logic [POS_W-1:0]   pos_i,
    input  logic [FETCH_W-1:0] fetch_i,
    input  logic               done_i,
    input  logic               any_i
);

    // R2: accepted load sets counter to the offset
    a_r2_load_offset: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (load_i && !valid_i) |=> (fetch_i == $past(base_i)));

    // R3: positions strictly ascend within a walk
    a_r3_pos_rising: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_i |=> (!valid_i || (pos_i > $past(pos_i))));

    // R3: held bitmap is nonempty whenever an entry is emitted
    a_r3_emit_has_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_i |-> any_i);

    // R4: counter steps by one between consecutive emissions
    a_r4_fetch_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_i |=> (!valid_i || ((fetch_i - $past(fetch_i)) == FETCH_W'(1))));

    // R5: empty bitmap goes straight to done
    a_r5_empty_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (load_i && !valid_i && (map_i == '0)) |=> (done_i && !valid_i));

    // R6: done holds with a stable counter until a load
    a_r6_done_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_i && !load_i) |=> (done_i && $stable(fetch_i)));

    // R6: done and valid exclusive
    a_r6_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(valid_i && done_i));

    // R7: load during a walk does not restart it
    a_r7_busy_load_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_i && load_i) |=> (done_i || ((fetch_i - $past(fetch_i)) == FETCH_W'(1))));

    // R8: position quiet when not valid
    a_r8_pos_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !valid_i |-> (pos_i == '0));

endmodule

bind sparse_idx_decoder sparse_idx_decoder_chk #(
    .MAP_W   (MAP_W),
    .FETCH_W (FETCH_W)
) u_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load_i),
    .map_i   (map_i),
    .base_i  (base_i),
    .valid_i (valid_o),
    .pos_i   (pos_o),
    .fetch_i (fetch_o),
    .done_i  (done_o),
    .any_i   (lb_any)
);

// File: tb/sparse_idx_decoder_tb.sv
module sparse_idx_decoder_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load = 1'b0;
    logic [15:0] map = '0;
    logic [9:0]  base = '0;
    logic        valid;
    logic [3:0]  pos;
    logic [9:0]  fetch;
    logic        done;

    int    n_vec = 0;
    int    n_bad = 0;
    string cur_tag = "R1";
    bit    finished = 0;

    // reference model state
    int m_q[$];
    bit m_busy = 0;
    bit m_done = 0;
    int m_fetch = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sparse_idx_decoder u_dut (
        .clk_i   (clk),
        .rst_ni  (rst_n),
        .load_i  (load),
        .map_i   (map),
        .base_i  (base),
        .valid_o (valid),
        .pos_o   (pos),
        .fetch_o (fetch),
        .done_o  (done)
    );

    // behavioural reference: a queue of pending positions
    always @(posedge clk) begin
        if (!rst_n) begin
            m_q.delete();
            m_busy  = 0;
            m_done  = 0;
            m_fetch = 0;
        end else if (load && !m_busy) begin
            m_q.delete();
            for (int i = 0; i < 16; i++) if (map[i]) m_q.push_back(i);
            m_fetch = int'(base);
            m_busy  = (m_q.size() > 0);
            m_done  = !m_busy;
        end else if (m_busy) begin
            void'(m_q.pop_front());
            m_fetch = (m_fetch + 1) % 1024;
            if (m_q.size() == 0) begin
                m_busy = 0;
                m_done = 1;
            end
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s/%s %s actual=%0d expected=%0d at %0t",
                     cur_tag, req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!finished) begin
            chk("R3", "valid_o", int'(valid), int'(m_busy));
            chk(m_busy ? "R3" : "R8", "pos_o", int'(pos), m_busy ? m_q[0] : 0);
            chk("R4", "fetch_o", int'(fetch), m_fetch);
            chk("R6", "done_o", int'(done), int'(m_done));
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic run(input logic [15:0] m, input logic [9:0] b);
        load = 1'b1;
        map  = m;
        base = b;
        tick();
        load = 1'b0;
        while (!m_done) tick();
    endtask

    task automatic finish_run();
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired, no completion");
        finish_run();
    end

    initial begin
        logic [31:0] lfsr;
        // R1: reset state checked on the negedges while reset is low
        cur_tag = "R1";
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        tick();

        // R5: empty bitmap from idle, then done holds (R6)
        cur_tag = "R5";
        run(16'h0000, 10'd5);
        cur_tag = "R6";
        repeat (4) tick();

        // R9: boundary bitmaps; R2 loads straight from done
        cur_tag = "R9";
        run(16'hFFFF, 10'd0);
        run(16'h8000, 10'd1023);
        run(16'h0001, 10'd7);
        run(16'h8001, 10'd300);
        run(16'h00FF, 10'd1020);   // counter wraps mid-walk
        tick();

        // R7: load held high during a walk with other inputs
        cur_tag = "R7";
        load = 1'b1; map = 16'hA5A5; base = 10'd100;
        tick();
        map = 16'hFFFF; base = 10'd0;
        tick(); tick(); tick();
        load = 1'b0;
        while (!m_done) tick();
        repeat (2) tick();

        // R2: back-to-back loads, each issued in the first done cycle
        cur_tag = "R2";
        run(16'h0C30, 10'd512);
        run(16'h0000, 10'd9);
        run(16'h4002, 10'd1022);

        // R3: pseudo-random bitmaps and offsets with random gaps
        cur_tag = "R3";
        lfsr = 32'hACE1_2357;
        for (int t = 0; t < 300; t++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            run(lfsr[15:0] & {16{lfsr[20] | lfsr[21]}} | (lfsr[15:0] & lfsr[31:16]),
                lfsr[29:20]);
            if (lfsr[3]) tick();
        end
        tick();
        finish_run();
    end

endmodule